// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a bank of small memory-mapped control registers for a workstation I/O companion chip. A simple register bus reaches it, with one select line per register region. The bank holds three plain byte registers (configuration, diagnostic, modem control), two auxiliary byte registers with side effects, a 16-bit diagnostic LED register and a 32-bit system-control register. Read data is combinational from the stored state. A write takes effect at the clock edge on which it is presented.

Four outputs leave the bank. A level power-fail interrupt is raised when a latched power-fail status bit and an enable bit in the configuration register are both set. A one-cycle floppy terminal-count pulse comes from a trigger bit in the first auxiliary register. A one-cycle shutdown request comes from a power-off bit in the second auxiliary register. A one-cycle system reset request comes from the system-control register.

Each region accepts only its own access width. A write of any other width changes nothing, and a read of any other width returns zero. A synchronous reset clears the registers tied to interrupt and control. It keeps the diagnostic, LED and system-control contents.

Top module: `auxctl_top`

## Requirements
- R1: Region select bits are: 0 configuration, 1 diagnostic, 2 modem control, 3 first auxiliary, 4 second auxiliary, 5 LED, 6 system control. The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for invalid. Byte regions take code 0, LED takes code 1 and system control takes code 2. An access counts only when exactly one select is high and the size code matches that region. Any other write changes no state and raises no pulse. Any other read returns 0.
- R2: The configuration, diagnostic and modem-control registers store all 8 written bits. They read back zero-extended to 32 bits.
- R3: A write to the first auxiliary register stores all 8 bits except bit 2, which always reads 0. If bit 2 of the data is 1, the terminal-count output is high for exactly the one cycle after the write edge.
- R4: A write to the second auxiliary register stores only data bits 1:0. The power-fail status is read at bit 5 and cannot be set by a write. Writing bit 1 as 1 clears the status. Otherwise the status is preserved.
- R5: Writing bit 0 of the second auxiliary register as 1 raises the shutdown request for exactly the one cycle after the write edge.
- R6: A rising edge of the power-fail input sets the status if configuration bit 3 (the enable) is 1 at that edge, and clears it if the enable is 0. A falling edge of the input clears the status. An input edge takes priority over a clear written in the same cycle.
- R7: The interrupt output is high exactly when the power-fail status and configuration bit 3 are both 1. It follows changes to either bit after the updating edge.
- R8: The LED register stores and returns 16 bits.
- R9: A system-control write with bit 0 set loads the value 0x2 and raises the reset request for exactly one cycle. A write with bit 0 clear stores the full 32-bit word.
- R10: Reset clears the configuration, both auxiliary registers (including the status), the modem-control register and all pulse outputs. The diagnostic, LED and system-control registers keep their contents across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regSel | input | 7 | One select per register region |
| wrEn | input | 1 | 1 = write, 0 = read |
| accSize | input | 2 | Access size code |
| wrData | input | 32 | Write data |
| pwrFailIn | input | 1 | External power-fail indication |
| rdData | output | 32 | Read data of the selected region |
| pwrIrq | output | 1 | Power-fail interrupt level |
| fdcTc | output | 1 | Floppy terminal-count pulse |
| shutdownReq | output | 1 | Shutdown request pulse |
| resetReq | output | 1 | System reset request pulse |

## Verification
A wrong power-fail status shows up in two places one cycle after the edge that corrupted it: as a wrong interrupt level, and as a wrong bit 5 on any read of the second auxiliary register. A width-check fault makes a rejected write visible on the next read of that region. It can also produce a stray pulse in the cycle right after the bad write. Reset retention faults surface only when the kept registers are read after a reset. For that reason the bench loads those registers with non-zero patterns before it pulses reset.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
  localparam int NUM_REGIONS = 7;

  // region indices (select bit positions)
  localparam int RG_CFG   = 0;
  localparam int RG_DIAG  = 1;
  localparam int RG_MODEM = 2;
  localparam int RG_AUX1  = 3;
  localparam int RG_AUX2  = 4;
  localparam int RG_LED   = 5;
  localparam int RG_SYS   = 6;

  // bit positions that give the registers their behaviour
  localparam int PF_EN_BIT    = 3;
  localparam int PF_STAT_BIT  = 5;
  localparam int TC_BIT       = 2;
  localparam int PWROFF_BIT   = 0;
  localparam int INTCLR_BIT   = 1;
  localparam int SYS_RST_BIT  = 0;
  localparam int SYS_STAT_BIT = 1;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    logic [NUM_REGIONS-1:0] wr;
    logic [NUM_REGIONS-1:0] rd;
  } strobes_t;

  function automatic logic [1:0] regionSize(input int idx);
    case (idx)
      RG_LED:  regionSize = SZ_HALF;
      RG_SYS:  regionSize = SZ_WORD;
      default: regionSize = SZ_BYTE;
    endcase
  endfunction
endpackage

// File: rtl/auxctl_ctrl.sv
module auxctl_ctrl
  import auxctl_pkg::*;
(
  input  logic [NUM_REGIONS-1:0] regSel,
  input  logic                   wrEn,
  input  logic [1:0]             accSize,
  output strobes_t               strb
);
  logic                   singleSel;
  logic [NUM_REGIONS-1:0] wrVec;
  logic [NUM_REGIONS-1:0] rdVec;

  assign singleSel = (regSel != '0) && ((regSel & (regSel - 1'b1)) == '0);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic sizeOk;
    assign sizeOk   = (accSize == regionSize(g));
    assign rdVec[g] = singleSel & regSel[g] & sizeOk;
    assign wrVec[g] = rdVec[g] & wrEn;
  end

  assign strb = '{wr: wrVec, rd: rdVec};
endmodule

// File: rtl/auxctl_regs.sv
module auxctl_regs
  import auxctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pwrFailIn,
  output logic [DATA_W-1:0] rdData,
  output logic              pwrIrq,
  output logic              fdcTc,
  output logic              shutdownReq,
  output logic              resetReq
);
  localparam int NUM_PLAIN = 3;
  // plain byte registers cleared by reset: configuration and modem, not diagnostic
  localparam logic [NUM_PLAIN-1:0] CLR_ON_RST = 3'b101;
  localparam logic [BYTE_W-1:0] TC_MASK = ~(BYTE_W'(1) << TC_BIT);

  logic [NUM_PLAIN-1:0][BYTE_W-1:0] plainRegs;
  logic [BYTE_W-1:0] cfgReg;
  logic [BYTE_W-1:0] aux1Reg;
  logic [1:0]        aux2Low;
  logic              pfStat;
  logic              pfPrev;
  logic              pfRise;
  logic              pfFall;
  logic [LED_W-1:0]  ledReg;
  logic [DATA_W-1:0] sysReg;

  // plain byte registers
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    logic [BYTE_W-1:0] q;
    if (CLR_ON_RST[g]) begin : g_clr
      always_ff @(posedge clk) begin
        if (!rstN)           q <= '0;
        else if (strb.wr[g]) q <= wrData[BYTE_W-1:0];
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (strb.wr[g]) q <= wrData[BYTE_W-1:0];
      end
    end
    assign plainRegs[g] = q;
  end

  assign cfgReg = plainRegs[RG_CFG];

  // first auxiliary register and terminal-count pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aux1Reg <= '0;
      fdcTc   <= 1'b0;
    end else begin
      if (strb.wr[RG_AUX1]) aux1Reg <= wrData[BYTE_W-1:0] & TC_MASK;
      fdcTc <= strb.wr[RG_AUX1] & wrData[TC_BIT];
    end
  end

  // power-fail edge detection
  assign pfRise = pwrFailIn & ~pfPrev;
  assign pfFall = ~pwrFailIn & pfPrev;

  // second auxiliary register, status and shutdown pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aux2Low     <= '0;
      pfStat      <= 1'b0;
      pfPrev      <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      pfPrev <= pwrFailIn;
      if (strb.wr[RG_AUX2]) aux2Low <= wrData[1:0];
      if (pfRise)                                      pfStat <= cfgReg[PF_EN_BIT];
      else if (pfFall)                                 pfStat <= 1'b0;
      else if (strb.wr[RG_AUX2] && wrData[INTCLR_BIT]) pfStat <= 1'b0;
      shutdownReq <= strb.wr[RG_AUX2] & wrData[PWROFF_BIT];
    end
  end

  assign pwrIrq = pfStat & cfgReg[PF_EN_BIT];

  // LED register, kept across reset
  always_ff @(posedge clk) begin
    if (strb.wr[RG_LED]) ledReg <= wrData[LED_W-1:0];
  end

  // system control, kept across reset
  always_ff @(posedge clk) begin
    if (strb.wr[RG_SYS]) begin
      if (wrData[SYS_RST_BIT]) sysReg <= DATA_W'(1) << SYS_STAT_BIT;
      else                     sysReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= strb.wr[RG_SYS] & wrData[SYS_RST_BIT];
  end

  // read-back
  logic [DATA_W-1:0] regVal [NUM_REGIONS];
  always_comb begin
    for (int i = 0; i < NUM_PLAIN; i++) regVal[i] = DATA_W'(plainRegs[i]);
    regVal[RG_AUX1] = DATA_W'(aux1Reg);
    regVal[RG_AUX2] = DATA_W'(aux2Low) | (DATA_W'(pfStat) << PF_STAT_BIT);
    regVal[RG_LED]  = DATA_W'(ledReg);
    regVal[RG_SYS]  = sysReg;
    rdData = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (strb.rd[i]) rdData = rdData | regVal[i];
    end
  end

  // R6
  stat_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfStat) |-> $past(cfgReg[PF_EN_BIT]));

  // R4
  intclr_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr[RG_AUX2] && wrData[INTCLR_BIT] && !pfRise) |=> !pfStat);

  // R5
  shutdown_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> aux2Low[PWROFF_BIT]);

  // R9
  reset_req_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (sysReg == (DATA_W'(1) << SYS_STAT_BIT)));
endmodule

// File: rtl/auxctl_top.sv
module auxctl_top
  import auxctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LED_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_REGIONS-1:0] regSel,
  input  logic                   wrEn,
  input  logic [1:0]             accSize,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   pwrFailIn,
  output logic [DATA_W-1:0]      rdData,
  output logic                   pwrIrq,
  output logic                   fdcTc,
  output logic                   shutdownReq,
  output logic                   resetReq
);
  strobes_t strb;

  auxctl_ctrl i_ctrl (
    .regSel  (regSel),
    .wrEn    (wrEn),
    .accSize (accSize),
    .strb    (strb)
  );

  auxctl_regs #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .LED_W  (LED_W)
  ) i_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .pwrFailIn   (pwrFailIn),
    .rdData      (rdData),
    .pwrIrq      (pwrIrq),
    .fdcTc       (fdcTc),
    .shutdownReq (shutdownReq),
    .resetReq    (resetReq)
  );

  // R1
  bad_size_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'd3) |-> (rdData == '0));

  // R1
  multi_sel_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(regSel) > 1) |-> (rdData == '0));

  // R3
  tc_from_valid_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    fdcTc |-> $past(regSel == NUM_REGIONS'(1 << RG_AUX1) && wrEn
                    && accSize == SZ_BYTE && wrData[TC_BIT]));
endmodule

// File: tb/test_auxctl_top.sv
module test_auxctl_top;
  localparam int VEC_W = 3 + 2 + 32 + 32;
  localparam int NVEC  = 16;

  // {region, write size, write data, expected read-back}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {3'd0, 2'd0, 32'h0000_00A5, 32'h0000_00A5},  // R2 cfg
    {3'd1, 2'd0, 32'h0000_003C, 32'h0000_003C},  // R2 diag
    {3'd2, 2'd0, 32'hFFFF_FFFF, 32'h0000_00FF},  // R2 modem
    {3'd3, 2'd0, 32'h0000_00FF, 32'h0000_00FB},  // R3 bit2 reads 0
    {3'd3, 2'd0, 32'h0000_0012, 32'h0000_0012},  // R3
    {3'd4, 2'd0, 32'h0000_00FC, 32'h0000_0000},  // R4 only 1:0 kept
    {3'd4, 2'd0, 32'h0000_0001, 32'h0000_0001},  // R4
    {3'd5, 2'd1, 32'h0000_BEEF, 32'h0000_BEEF},  // R8
    {3'd6, 2'd2, 32'h0000_0002, 32'h0000_0002},  // R9
    {3'd6, 2'd2, 32'hCAFE_0000, 32'hCAFE_0000},  // R9 full word
    {3'd0, 2'd1, 32'h0000_0000, 32'h0000_00A5},  // R1 wrong width
    {3'd5, 2'd0, 32'h0000_1234, 32'h0000_BEEF},  // R1
    {3'd6, 2'd0, 32'h0000_0001, 32'hCAFE_0000},  // R1
    {3'd1, 2'd2, 32'h0000_0000, 32'h0000_003C},  // R1
    {3'd4, 2'd0, 32'h0000_0000, 32'h0000_0000},  // R4
    {3'd0, 2'd0, 32'h0000_0008, 32'h0000_0008}   // R2
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  regSel = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  accSize = '0;
  logic [31:0] wrData = '0;
  logic        pwrFailIn = 1'b0;
  logic [31:0] rdData;
  logic        pwrIrq, fdcTc, shutdownReq, resetReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  auxctl_top i_auxctl_top (
    .clk, .rstN, .regSel, .wrEn, .accSize, .wrData, .pwrFailIn,
    .rdData, .pwrIrq, .fdcTc, .shutdownReq, .resetReq
  );

  function automatic logic [1:0] sizeOf(input int idx);
    if (idx == 5) return 2'd1;
    if (idx == 6) return 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int idx, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    regSel = 7'(1 << idx); wrEn = 1'b1; accSize = sz; wrData = d;
    @(negedge clk);
    regSel = '0; wrEn = 1'b0; accSize = '0; wrData = '0;
  endtask

  task automatic busRead(input logic [6:0] sel, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    regSel = sel; wrEn = 1'b0; accSize = sz;
    #1 d = rdData;
    regSel = '0;
  endtask

  task automatic readReg(input int idx, output logic [31:0] d);
    busRead(7'(1 << idx), sizeOf(idx), d);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    chk("R10 irq", 32'(pwrIrq), 0);
    chk("R10 tc", 32'(fdcTc), 0);
    chk("R10 shutdown", 32'(shutdownReq), 0);
    chk("R10 resetReq", 32'(resetReq), 0);
    readReg(0, r); chk("R10 cfg", r, 0);
    readReg(3, r); chk("R10 aux1", r, 0);
    readReg(4, r); chk("R10 aux2", r, 0);
    readReg(2, r); chk("R10 modem", r, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [VEC_W-1:0] v;
      v = VECS[i];
      busWrite(int'(v[68:66]), v[65:64], v[63:32]);
      readReg(int'(v[68:66]), r);
      chk($sformatf("R1/R2 vector %0d", i), r, v[31:0]);
    end

    // R9 reset request and reset retention (R10)
    busWrite(6, 2'd2, 32'h0000_0001);
    chk("R9 resetReq pulse", 32'(resetReq), 1);
    @(negedge clk); chk("R9 resetReq one cycle", 32'(resetReq), 0);
    readReg(6, r); chk("R9 sys value", r, 32'h2);
    busWrite(0, 2'd0, 32'h0000_00A5);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    readReg(0, r); chk("R10 cfg cleared", r, 0);
    readReg(2, r); chk("R10 modem cleared", r, 0);
    readReg(1, r); chk("R10 diag kept", r, 32'h3C);
    readReg(5, r); chk("R10 led kept", r, 32'hBEEF);
    readReg(6, r); chk("R10 sys kept", r, 32'h2);

    // R6 / R7 power-fail path
    busWrite(0, 2'd0, 32'h08);
    pwrFailIn = 1'b1;
    @(negedge clk);
    chk("R7 irq raised", 32'(pwrIrq), 1);
    readReg(4, r); chk("R6 status set", r, 32'h20);
    busWrite(4, 2'd0, 32'h00);
    readReg(4, r); chk("R4 status preserved", r, 32'h20);
    chk("R7 irq held", 32'(pwrIrq), 1);
    busWrite(0, 2'd0, 32'h00);
    chk("R7 irq off when disabled", 32'(pwrIrq), 0);
    readReg(4, r); chk("R4 status kept while disabled", r, 32'h20);
    busWrite(0, 2'd0, 32'h08);
    chk("R7 irq back on", 32'(pwrIrq), 1);
    busWrite(4, 2'd0, 32'h02);
    readReg(4, r); chk("R4 clear bit", r, 32'h02);
    chk("R7 irq after clear", 32'(pwrIrq), 0);
    pwrFailIn = 1'b0;
    @(negedge clk);
    pwrFailIn = 1'b1;
    @(negedge clk);
    readReg(4, r); chk("R6 re-set on new rise", r, 32'h22);
    pwrFailIn = 1'b0;
    @(negedge clk);
    readReg(4, r); chk("R6 fall clears", r, 32'h02);
    chk("R7 irq after fall", 32'(pwrIrq), 0);
    busWrite(0, 2'd0, 32'h00);
    pwrFailIn = 1'b1;
    @(negedge clk);
    readReg(4, r); chk("R6 rise while disabled", r, 32'h02);
    busWrite(0, 2'd0, 32'h08);
    chk("R7 irq stays low", 32'(pwrIrq), 0);
    pwrFailIn = 1'b0;
    @(negedge clk);

    // R5 shutdown
    busWrite(4, 2'd0, 32'h01);
    chk("R5 shutdown pulse", 32'(shutdownReq), 1);
    @(negedge clk); chk("R5 shutdown one cycle", 32'(shutdownReq), 0);
    busWrite(4, 2'd0, 32'h02);
    chk("R5 no shutdown", 32'(shutdownReq), 0);

    // R3 terminal count
    busWrite(3, 2'd0, 32'h04);
    chk("R3 tc pulse", 32'(fdcTc), 1);
    @(negedge clk); chk("R3 tc one cycle", 32'(fdcTc), 0);
    readReg(3, r); chk("R3 trigger bit reads 0", r, 0);
    busWrite(3, 2'd1, 32'h04);
    chk("R1 wrong width no tc", 32'(fdcTc), 0);
    busWrite(3, 2'd0, 32'h01);
    chk("R3 no tc without bit2", 32'(fdcTc), 0);

    // R1 read-side checks
    busRead(7'b000_0001, 2'd2, r); chk("R1 wrong width read", r, 0);
    busRead(7'b000_0011, 2'd0, r); chk("R1 two selects", r, 0);
    busRead(7'b010_0000, 2'd3, r); chk("R1 invalid size", r, 0);
    busRead(7'b000_0000, 2'd0, r); chk("R1 no select", r, 0);

    finish();
  end
endmodule